// File: doc/BRIEF.md
# Conditional Prefetch Issue Queue

This block sits between a prefetch address generator and a data cache unit. Every generated prefetch line address is written into a small circular queue. The oldest queued address is offered to the cache store port only while the port is idle, enough fill-buffer slots are free, enough external bus-queue slots are free and no external traffic monitor is holding prefetching back. The head entry leaves the queue only in a cycle where all of these hold and the cache also accepts it. If the generator produces a new address while the queue is full, the new address replaces the oldest one. The generator is never stalled.

After acceptance, the cache reports whether the line was already present in its arrays or fill buffers. A present line makes the request vanish, and a drop pulse is raised. An absent line turns into a line read request to the lower levels, just as a demand miss would.

When a prefetched line comes back, a keep-policy input decides what happens to it. With the policy set to keep, the line is installed. With the policy set to discard, the line waits in a parking slot for a fixed window of cycles. A demand access to it during that window installs it. If the window runs out, or a newer returning line displaces it, the line is thrown away.

Top module: `pf_issue_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block raises none of `iss_v`, `drop_v`, `rd_req_v`, `inst_v`, `disc_v`.
- R2: Queued addresses are offered on `iss_addr` strictly oldest-first, one entry removed per cycle in which `iss_v` and `dcu_accept` are both high.
- R3: Pushing into a queue that already holds `DEPTH` (8) entries discards the oldest entry. When the queue is full and the head is accepted in the same cycle as a push, nothing is lost: the head leaves and the new address is appended.
- R4: `iss_v` is low unless `port_idle` is 1, `fb_free >= FB_THR` (2) and `bq_free >= BQ_THR` (3).
- R5: While `dcu_accept` is low, the offered head stays in the queue and `iss_addr` is unchanged.
- R6: A lookup result with `lookup_hit`=1 produces, one clock later, a one-cycle `drop_v` carrying `lookup_addr` and no `rd_req_v`.
- R7: A lookup result with `lookup_hit`=0 produces, one clock later, a one-cycle `rd_req_v` carrying `lookup_addr` and no `drop_v`.
- R8: A returning line with `keep_cfg`=1 is installed one clock later (`inst_v`=1, `inst_addr` = the line).
- R9: With `keep_cfg`=0, a returning line is parked. If no demand access matches it, it is discarded (`disc_v`) on the `PARK_CYCLES`-th (4th) clock after its arrival. A newer line arriving while one is parked discards the parked one at that clock.
- R10: With `keep_cfg`=0, a demand access (`dem_v`) to the parked line address, or to the returning line in its arrival cycle, installs the line one clock later, and no discard follows.
- R11: While `throttle` is high, `iss_v` is low and nothing leaves the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_v | input | 1 | New prefetch address from generator |
| gen_addr | input | AW | Line address to queue |
| port_idle | input | 1 | Cache store port idle |
| fb_free | input | FBW | Free fill-buffer entries |
| bq_free | input | BQW | Free external bus-queue entries |
| throttle | input | 1 | Stall from traffic monitor |
| dcu_accept | input | 1 | Cache unit takes the offered request |
| iss_v | output | 1 | Head offered to the store port |
| iss_addr | output | AW | Offered line address |
| lookup_v | input | 1 | Lookup result for an accepted request |
| lookup_hit | input | 1 | Line found in cache or fill buffers |
| lookup_addr | input | AW | Line address of the lookup |
| drop_v | output | 1 | Request dropped on hit |
| drop_addr | output | AW | Dropped line address |
| rd_req_v | output | 1 | Line read request to lower level |
| rd_req_addr | output | AW | Line address to read |
| keep_cfg | input | 1 | 1 installs returning lines, 0 discards unless demanded |
| fill_v | input | 1 | Prefetched line returning |
| fill_addr | input | AW | Returning line address |
| dem_v | input | 1 | Demand access observed |
| dem_addr | input | AW | Demand line address |
| inst_v | output | 1 | Install line into cache |
| inst_addr | output | AW | Line address to install |
| disc_v | output | 1 | Returning line discarded |
| disc_addr | output | AW | Discarded line address |

## Verification
Two queue functions can fall into one clock: a push into a completely full queue and the acceptance of its head. The bench provokes this by loading eight entries behind a closed gate. It then opens every condition with acceptance held high and pushes four more addresses back to back. The scoreboard model pops the accepted head before it appends the new address, so a design that treats the push as an overwrite as well would lose an entry. That loss shows up as a wrong or missing address in the issue order. A second collision is a returning line that meets a demand access in its arrival cycle. The bench judges it by an install pulse one clock later and the absence of any discard pulse afterwards.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  typedef enum logic {
    PARK_FREE = 1'b0,
    PARK_HELD = 1'b1
  } park_st_e;

  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_DROP = 2'd1,
    LK_READ = 2'd2
  } lk_out_e;

endpackage

// File: rtl/pfq_ring.sv
module pfq_ring #(
  parameter int AW    = 26,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic          empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full;
  logic          rd_adv;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  // head leaves on pop; on overwrite the oldest is skipped as well
  assign rd_adv = pop | (push & full);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_addr;
  end

  assign head_addr = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push)   wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_adv) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (push && !pop && !full) count <= count + 1'b1;
      else if (pop && !push)     count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/pfq_gate.sv
module pfq_gate #(
  parameter int FBW    = 4,
  parameter int BQW    = 4,
  parameter int FB_THR = 2,
  parameter int BQ_THR = 3
) (
  input  logic           port_idle,
  input  logic [FBW-1:0] fb_free,
  input  logic [BQW-1:0] bq_free,
  input  logic           throttle,
  output logic           open
);

  logic fb_ok, bq_ok;

  generate
    if (FB_THR == 0) begin : g_fb_any
      assign fb_ok = 1'b1;
    end else begin : g_fb_cmp
      localparam logic [FBW-1:0] FB_LIM = FBW'(FB_THR);
      assign fb_ok = (fb_free >= FB_LIM);
    end
    if (BQ_THR == 0) begin : g_bq_any
      assign bq_ok = 1'b1;
    end else begin : g_bq_cmp
      localparam logic [BQW-1:0] BQ_LIM = BQW'(BQ_THR);
      assign bq_ok = (bq_free >= BQ_LIM);
    end
  endgenerate

  assign open = port_idle & fb_ok & bq_ok & ~throttle;

endmodule

// File: rtl/pfq_lookup_resp.sv
module pfq_lookup_resp
  import pfq_pkg::*;
#(
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lookup_v,
  input  logic          lookup_hit,
  input  logic [AW-1:0] lookup_addr,
  output logic          drop_v,
  output logic [AW-1:0] drop_addr,
  output logic          rd_req_v,
  output logic [AW-1:0] rd_req_addr
);

  lk_out_e outcome;

  always_comb begin
    outcome = LK_NONE;
    if (lookup_v) outcome = lookup_hit ? LK_DROP : LK_READ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_v      <= 1'b0;
      rd_req_v    <= 1'b0;
      drop_addr   <= '0;
      rd_req_addr <= '0;
    end else begin
      drop_v   <= (outcome == LK_DROP);
      rd_req_v <= (outcome == LK_READ);
      if (outcome == LK_DROP) drop_addr   <= lookup_addr;
      if (outcome == LK_READ) rd_req_addr <= lookup_addr;
    end
  end

endmodule

// File: rtl/pfq_line_park.sv
module pfq_line_park
  import pfq_pkg::*;
#(
  parameter int AW          = 26,
  parameter int PARK_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          keep_cfg,
  input  logic          fill_v,
  input  logic [AW-1:0] fill_addr,
  input  logic          dem_v,
  input  logic [AW-1:0] dem_addr,
  output logic          inst_v,
  output logic [AW-1:0] inst_addr,
  output logic          disc_v,
  output logic [AW-1:0] disc_addr
);

  localparam int TW = (PARK_CYCLES > 1) ? $clog2(PARK_CYCLES) : 1;
  localparam logic [TW-1:0] T_INIT = TW'(PARK_CYCLES - 1);

  park_st_e      st;
  logic [AW-1:0] park_addr;
  logic [TW-1:0] tmr;
  logic          held_hit;
  logic          new_keep;

  assign held_hit = (st == PARK_HELD) && dem_v && (dem_addr == park_addr);
  assign new_keep = keep_cfg || (dem_v && (dem_addr == fill_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PARK_FREE;
      park_addr <= '0;
      tmr       <= '0;
      inst_v    <= 1'b0;
      inst_addr <= '0;
      disc_v    <= 1'b0;
      disc_addr <= '0;
    end else begin
      inst_v <= 1'b0;
      disc_v <= 1'b0;
      if (fill_v) begin
        if (st == PARK_HELD) begin
          disc_v    <= 1'b1;
          disc_addr <= park_addr;
        end
        if (new_keep) begin
          inst_v    <= 1'b1;
          inst_addr <= fill_addr;
          st        <= PARK_FREE;
        end else begin
          st        <= PARK_HELD;
          park_addr <= fill_addr;
          tmr       <= T_INIT;
        end
      end else if (st == PARK_HELD) begin
        if (held_hit) begin
          inst_v    <= 1'b1;
          inst_addr <= park_addr;
          st        <= PARK_FREE;
        end else if (tmr == '0) begin
          disc_v    <= 1'b1;
          disc_addr <= park_addr;
          st        <= PARK_FREE;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pf_issue_queue.sv
module pf_issue_queue #(
  parameter int AW          = 26,
  parameter int DEPTH       = 8,
  parameter int FBW         = 4,
  parameter int BQW         = 4,
  parameter int FB_THR      = 2,
  parameter int BQ_THR      = 3,
  parameter int PARK_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           gen_v,
  input  logic [AW-1:0]  gen_addr,
  input  logic           port_idle,
  input  logic [FBW-1:0] fb_free,
  input  logic [BQW-1:0] bq_free,
  input  logic           throttle,
  input  logic           dcu_accept,
  output logic           iss_v,
  output logic [AW-1:0]  iss_addr,
  input  logic           lookup_v,
  input  logic           lookup_hit,
  input  logic [AW-1:0]  lookup_addr,
  output logic           drop_v,
  output logic [AW-1:0]  drop_addr,
  output logic           rd_req_v,
  output logic [AW-1:0]  rd_req_addr,
  input  logic           keep_cfg,
  input  logic           fill_v,
  input  logic [AW-1:0]  fill_addr,
  input  logic           dem_v,
  input  logic [AW-1:0]  dem_addr,
  output logic           inst_v,
  output logic [AW-1:0]  inst_addr,
  output logic           disc_v,
  output logic [AW-1:0]  disc_addr
);

  logic q_empty;
  logic gate_open;
  logic take;

  assign iss_v = gate_open & ~q_empty;
  assign take  = iss_v & dcu_accept;

  pfq_ring #(.AW(AW), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .push      (gen_v),
    .push_addr (gen_addr),
    .pop       (take),
    .head_addr (iss_addr),
    .empty     (q_empty)
  );

  pfq_gate #(.FBW(FBW), .BQW(BQW), .FB_THR(FB_THR), .BQ_THR(BQ_THR)) u_gate (
    .port_idle (port_idle),
    .fb_free   (fb_free),
    .bq_free   (bq_free),
    .throttle  (throttle),
    .open      (gate_open)
  );

  pfq_lookup_resp #(.AW(AW)) u_lk (
    .clk         (clk),
    .rst         (rst),
    .lookup_v    (lookup_v),
    .lookup_hit  (lookup_hit),
    .lookup_addr (lookup_addr),
    .drop_v      (drop_v),
    .drop_addr   (drop_addr),
    .rd_req_v    (rd_req_v),
    .rd_req_addr (rd_req_addr)
  );

  pfq_line_park #(.AW(AW), .PARK_CYCLES(PARK_CYCLES)) u_park (
    .clk       (clk),
    .rst       (rst),
    .keep_cfg  (keep_cfg),
    .fill_v    (fill_v),
    .fill_addr (fill_addr),
    .dem_v     (dem_v),
    .dem_addr  (dem_addr),
    .inst_v    (inst_v),
    .inst_addr (inst_addr),
    .disc_v    (disc_v),
    .disc_addr (disc_addr)
  );

endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
  parameter int AW = 26
) (
  input logic          clk,
  input logic          rst,
  input logic          throttle,
  input logic          dcu_accept,
  input logic          gen_v,
  input logic          iss_v,
  input logic [AW-1:0] iss_addr,
  input logic          lookup_v,
  input logic          lookup_hit,
  input logic [AW-1:0] lookup_addr,
  input logic          drop_v,
  input logic [AW-1:0] drop_addr,
  input logic          rd_req_v,
  input logic [AW-1:0] rd_req_addr,
  input logic          keep_cfg,
  input logic          fill_v,
  input logic [AW-1:0] fill_addr,
  input logic          inst_v,
  input logic [AW-1:0] inst_addr,
  input logic          disc_v
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(drop_v || rd_req_v || inst_v || disc_v));

  assert_throttle_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    throttle |-> !iss_v);

  assert_head_held_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_v && !dcu_accept && !gen_v) |=> (!iss_v || iss_addr == $past(iss_addr)));

  assert_drop_on_hit_R6: assert property (@(posedge clk) disable iff (rst)
    drop_v |-> ($past(lookup_v && lookup_hit) && drop_addr == $past(lookup_addr)));

  assert_read_on_miss_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req_v |-> ($past(lookup_v && !lookup_hit) && rd_req_addr == $past(lookup_addr)));

  assert_keep_installs_R8: assert property (@(posedge clk) disable iff (rst)
    (fill_v && keep_cfg) |=> (inst_v && inst_addr == $past(fill_addr)));

endmodule

bind pf_issue_queue pfq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .throttle    (throttle),
  .dcu_accept  (dcu_accept),
  .gen_v       (gen_v),
  .iss_v       (iss_v),
  .iss_addr    (iss_addr),
  .lookup_v    (lookup_v),
  .lookup_hit  (lookup_hit),
  .lookup_addr (lookup_addr),
  .drop_v      (drop_v),
  .drop_addr   (drop_addr),
  .rd_req_v    (rd_req_v),
  .rd_req_addr (rd_req_addr),
  .keep_cfg    (keep_cfg),
  .fill_v      (fill_v),
  .fill_addr   (fill_addr),
  .inst_v      (inst_v),
  .inst_addr   (inst_addr),
  .disc_v      (disc_v)
);

// File: tb/sim_pf_issue_queue.sv
module sim_pf_issue_queue;

  localparam int CLK_P  = 10;
  localparam int AW     = 26;
  localparam int DEPTH  = 8;
  localparam int FBW    = 4;
  localparam int BQW    = 4;
  localparam int FB_THR = 2;
  localparam int BQ_THR = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gen_v = 0;
  logic [AW-1:0] gen_addr = '0;
  logic port_idle = 0;
  logic [FBW-1:0] fb_free = '0;
  logic [BQW-1:0] bq_free = '0;
  logic throttle = 0, dcu_accept = 0;
  logic iss_v;
  logic [AW-1:0] iss_addr;
  logic lookup_v = 0, lookup_hit = 0;
  logic [AW-1:0] lookup_addr = '0;
  logic drop_v, rd_req_v, inst_v, disc_v;
  logic [AW-1:0] drop_addr, rd_req_addr, inst_addr, disc_addr;
  logic keep_cfg = 0, fill_v = 0, dem_v = 0;
  logic [AW-1:0] fill_addr = '0, dem_addr = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string mon_tag = "R2";
  logic [AW-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  pf_issue_queue u0 (
    .clk(clk), .rst(rst), .gen_v(gen_v), .gen_addr(gen_addr),
    .port_idle(port_idle), .fb_free(fb_free), .bq_free(bq_free),
    .throttle(throttle), .dcu_accept(dcu_accept),
    .iss_v(iss_v), .iss_addr(iss_addr),
    .lookup_v(lookup_v), .lookup_hit(lookup_hit), .lookup_addr(lookup_addr),
    .drop_v(drop_v), .drop_addr(drop_addr),
    .rd_req_v(rd_req_v), .rd_req_addr(rd_req_addr),
    .keep_cfg(keep_cfg), .fill_v(fill_v), .fill_addr(fill_addr),
    .dem_v(dem_v), .dem_addr(dem_addr),
    .inst_v(inst_v), .inst_addr(inst_addr),
    .disc_v(disc_v), .disc_addr(disc_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all stimulus tasks start and end one time unit after a rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_cyc(input logic [AW-1:0] a);
    gen_v = 1'b1;
    gen_addr = a;
    @(posedge clk);
    if (exp_q.size() == DEPTH) void'(exp_q.pop_front());
    exp_q.push_back(a);
    #1;
    gen_v = 1'b0;
  endtask

  task automatic gate_all(input logic on);
    port_idle = on;
    fb_free = FBW'(FB_THR);
    bq_free = BQW'(BQ_THR);
    throttle = 1'b0;
  endtask

  // scoreboard monitor: compare every accepted head with the model
  always @(negedge clk) begin
    if (!rst && iss_v && dcu_accept) begin
      if (exp_q.size() == 0) chk({mon_tag, " unexpected issue"}, {38'd0, iss_addr}, 64'hdead);
      else chk({mon_tag, " issue order"}, {38'd0, iss_addr}, {38'd0, exp_q.pop_front()});
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 iss_v in reset", {63'd0, iss_v}, 64'd0);
    rst = 1'b0;
    tick();
    chk("R1 outputs after reset", {60'd0, drop_v, rd_req_v, inst_v, disc_v}, 64'd0);
    chk("R1 iss_v after reset", {63'd0, iss_v}, 64'd0);

    // R4/R11 gating and R2/R5 head behaviour
    gate_all(1'b0);
    push_cyc(26'h10); push_cyc(26'h11); push_cyc(26'h12);
    chk("R4 port busy", {63'd0, iss_v}, 64'd0);
    port_idle = 1'b1; fb_free = FBW'(FB_THR - 1); #1;
    chk("R4 fill buffers short", {63'd0, iss_v}, 64'd0);
    fb_free = FBW'(FB_THR); bq_free = BQW'(BQ_THR - 1); #1;
    chk("R4 bus queue short", {63'd0, iss_v}, 64'd0);
    bq_free = BQW'(BQ_THR); throttle = 1'b1; #1;
    chk("R11 throttle", {63'd0, iss_v}, 64'd0);
    tick();
    chk("R11 throttle holds", {63'd0, iss_v}, 64'd0);
    throttle = 1'b0; #1;
    chk("R4 all open", {63'd0, iss_v}, 64'd1);
    chk("R2 head first", {38'd0, iss_addr}, 64'h10);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 head held", {38'd0, iss_addr}, 64'h10);
    end
    dcu_accept = 1'b1;
    repeat (4) tick();
    chk("R2 drained", {63'd0, iss_v}, 64'd0);
    chk("R2 model empty", 64'(exp_q.size()), 64'd0);
    dcu_accept = 1'b0;

    // R3 overwrite when full
    mon_tag = "R3";
    gate_all(1'b0);
    for (int i = 0; i < 10; i++) push_cyc(AW'(26'h100 + i));
    gate_all(1'b1); dcu_accept = 1'b1; #1;
    chk("R3 oldest overwritten", {38'd0, iss_addr}, 64'h102);
    repeat (10) tick();
    chk("R3 drained", 64'(exp_q.size()), 64'd0);
    chk("R3 empty after drain", {63'd0, iss_v}, 64'd0);
    dcu_accept = 1'b0;

    // R3 push into full queue while head is accepted
    gate_all(1'b0);
    for (int i = 0; i < 8; i++) push_cyc(AW'(26'h200 + i));
    gate_all(1'b1); dcu_accept = 1'b1;
    for (int i = 0; i < 4; i++) push_cyc(AW'(26'h300 + i));
    repeat (10) tick();
    chk("R3 collision drained", 64'(exp_q.size()), 64'd0);
    dcu_accept = 1'b0; gate_all(1'b0);

    // R6/R7 lookup outcomes
    lookup_v = 1'b1; lookup_hit = 1'b1; lookup_addr = 26'h3a1;
    tick();
    lookup_v = 1'b0;
    chk("R6 drop pulse", {62'd0, drop_v, rd_req_v}, 64'b10);
    chk("R6 drop addr", {38'd0, drop_addr}, 64'h3a1);
    tick();
    chk("R6 pulse ends", {63'd0, drop_v}, 64'd0);
    lookup_v = 1'b1; lookup_hit = 1'b0; lookup_addr = 26'h3b2;
    tick();
    lookup_v = 1'b0;
    chk("R7 read pulse", {62'd0, drop_v, rd_req_v}, 64'b01);
    chk("R7 read addr", {38'd0, rd_req_addr}, 64'h3b2);

    // R8 keep policy
    keep_cfg = 1'b1; fill_v = 1'b1; fill_addr = 26'h4c0;
    tick();
    fill_v = 1'b0;
    chk("R8 install", {62'd0, inst_v, disc_v}, 64'b10);
    chk("R8 install addr", {38'd0, inst_addr}, 64'h4c0);

    // R9 discard after window
    keep_cfg = 1'b0; fill_v = 1'b1; fill_addr = 26'h4d0;
    tick();
    fill_v = 1'b0;
    dem_v = 1'b1; dem_addr = 26'h999;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 parked quiet", {62'd0, inst_v, disc_v}, 64'd0);
    end
    tick();
    dem_v = 1'b0;
    chk("R9 discard at window end", {62'd0, inst_v, disc_v}, 64'b01);
    chk("R9 discard addr", {38'd0, disc_addr}, 64'h4d0);

    // R10 demand hit on parked line
    fill_v = 1'b1; fill_addr = 26'h4e0;
    tick();
    fill_v = 1'b0; dem_v = 1'b1; dem_addr = 26'h4e0;
    tick();
    dem_v = 1'b0;
    chk("R10 demand installs", {62'd0, inst_v, disc_v}, 64'b10);
    chk("R10 install addr", {38'd0, inst_addr}, 64'h4e0);
    repeat (5) begin
      tick();
      chk("R10 no later discard", {63'd0, disc_v}, 64'd0);
    end

    // R10 demand in arrival cycle
    fill_v = 1'b1; fill_addr = 26'h4f0; dem_v = 1'b1; dem_addr = 26'h4f0;
    tick();
    fill_v = 1'b0; dem_v = 1'b0;
    chk("R10 same-cycle demand", {62'd0, inst_v, disc_v}, 64'b10);

    // R9 displacement by a newer line
    fill_v = 1'b1; fill_addr = 26'h510;
    tick();
    fill_addr = 26'h520;
    tick();
    fill_v = 1'b0;
    chk("R9 displaced discard", {62'd0, inst_v, disc_v}, 64'b01);
    chk("R9 displaced addr", {38'd0, disc_addr}, 64'h510);
    repeat (3) tick();
    chk("R9 newer still parked", {63'd0, disc_v}, 64'd0);
    tick();
    chk("R9 newer discarded", {63'd0, disc_v}, 64'd1);
    chk("R9 newer addr", {38'd0, disc_addr}, 64'h520);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule